// File: doc/BRIEF.md
# D-PHY Low-Power Start-of-Burst Entry Monitor

This block observes the low-power line pair of a single D-PHY data lane, together with a digitised high-speed activity indication, and judges whether every high-speed burst was entered through the proper low-power approach. The legal approach leaves the stop state (both lines high), passes through LP-01 and then LP-00, and only then shows high-speed activity. While the lane crosses this approach, the monitor counts, in sample ticks, how long it stays in each low state and how long the whole low plateau lasts.

Each time a burst begins, the block gives exactly one verdict. It raises a one-cycle good-start pulse, or it raises a one-cycle fault pulse that carries a fault code. In both cases the measured plateau length comes with the pulse. A failed entry also sets a sticky error flag. The flag stays set until the lane is seen back in the stop state, because a receiver cannot resynchronise before that happens. All inputs come in asynchronously. They are synchronised, and short glitches are filtered out, before any classification.

The duration limits are given in picoseconds and are turned into tick counts from the sample period. The conversion rounds up, so a limit is never met early. Both the report outputs and the error flag are plain status pins. A monitor cannot stall the lane it watches, so these pins have no back-pressure: a downstream consumer must accept each pulse in the cycle it appears.

Top module: `lp_entry_monitor`

## Requirements
- R1: The lane code is {lp_dp, lp_dn}, and stop is 2'b11 with hs_det low. The input hs_det high means high-speed activity, whatever the line levels are. The legal order is stop, then 01, then 00, then hs_det high. If each low state lasts at least TLPX ticks and the combined plateau lasts at least PLAT ticks, the block gives a one-cycle start_ok pulse. With that pulse, fault_code is 0 and plat_len equals the number of samples spent in 01 plus the number spent in 00.
- R2: A legal order whose combined 01+00 plateau is shorter than PLAT = ceil(PLAT_PS/SAMPLE_PS) ticks gives a one-cycle start_fault pulse with fault_code 1 (truncated).
- R3: A legal order in which either LP-01 or LP-00 alone is shorter than TLPX = ceil(TLPX_PS/SAMPLE_PS) ticks gives fault_code 1, even when the combined plateau is long enough.
- R4: If hs_det rises while the lane is in the stop state, the block gives start_fault with fault_code 2 (absent) and plat_len 0.
- R5: Any other departure from the legal order gives start_fault with fault_code 3 (bad order). Examples are stop to 00, stop to 10, 01 to 10, 01 straight to high-speed, and 00 to any line code other than 00. With that pulse, plat_len holds the plateau counted so far.
- R6: err_flag rises in the same cycle as the start_fault pulse. It stays high, and no report is issued, until the lane shows stop (hs_det low). err_flag clears when that stop state is seen.
- R7: Every input passes a two-flop synchroniser. A change is accepted only after it has been stable for two samples, so a change that lasts a single sample has no effect.
- R8: The plateau count saturates at 2^CNT_W-1 and does not wrap. A saturated value is reported as it is.
- R9: A synchronous active-high rst clears start_ok, start_fault and err_flag. After rst the block ignores the lane until it sees the stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock, period SAMPLE_PS |
| rst | input | 1 | Synchronous active-high reset |
| lp_dp | input | 1 | Digitised positive-line low-power level (asynchronous) |
| lp_dn | input | 1 | Digitised negative-line low-power level (asynchronous) |
| hs_det | input | 1 | Digitised high-speed activity indication (asynchronous) |
| start_ok | output | 1 | One-cycle pulse: burst entered legally |
| start_fault | output | 1 | One-cycle pulse: burst entry faulty |
| fault_code | output | 2 | 0 none, 1 truncated, 2 absent, 3 bad order; valid with either pulse |
| plat_len | output | CNT_W | Measured plateau length in ticks; valid with either pulse |
| err_flag | output | 1 | Sticky error, cleared by the next stop state |

## Verification
A fault verdict and the rise of the sticky flag fall in the same clock, and this is the coincidence the bench targets. It provokes the case by driving the lane from stop straight into high-speed activity. It then captures err_flag in the very sample that holds the fault pulse and requires the flag to be high there and no earlier. A second coincidence comes from holding LP-00 long enough to saturate the plateau count right before high-speed starts. The verdict in that case must still be a good start, with the saturated length reported as it is.

// File: rtl/lpmon_pkg.sv
package lpmon_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TRUNC  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_ORDER  = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_STOP,
    ST_LO1,
    ST_LO0,
    ST_BURST
  } seq_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_NEW01,
    OP_INC01,
    OP_NEW00,
    OP_INC00
  } cnt_op_e;

  typedef struct packed {
    logic hs;
    logic dp;
    logic dn;
  } lane_t;

  localparam int LANE_W = $bits(lane_t);

  localparam logic [1:0] CODE_STOP = 2'b11;
  localparam logic [1:0] CODE_LO1  = 2'b01;
  localparam logic [1:0] CODE_LO0  = 2'b00;
endpackage

// File: rtl/lpmon_sync.sv
module lpmon_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0] chain [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[b] <= '0;
      else     chain[b] <= {chain[b][STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/lpmon_deglitch.sv
module lpmon_deglitch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] prev_q;
  logic [W-1:0] filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      filt_q <= '0;
    end else begin
      prev_q <= d_in;
      if (d_in == prev_q) filt_q <= d_in;
    end
  end

  assign d_out = filt_q;
endmodule

// File: rtl/lpmon_seq.sv
module lpmon_seq
  import lpmon_pkg::*;
#(
  parameter int               CNT_W  = 8,
  parameter logic [CNT_W-1:0] TLPX_T = 5,
  parameter logic [CNT_W-1:0] PLAT_T = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  lane_t            lane,
  output logic             ok_o,
  output logic             flt_o,
  output logic [1:0]       code_o,
  output logic [CNT_W-1:0] len_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_e             state, nstate;
  cnt_op_e          op;
  fault_e           rcode;
  logic             do_ok, do_flt, clr_err, short_plat;
  logic [CNT_W-1:0] c01, c00, plat;
  logic [CNT_W-1:0] c01_nx, c00_nx, plat_nx, rlen;
  logic [1:0]       lp;
  logic             is_stop;

  assign lp      = {lane.dp, lane.dn};
  assign is_stop = !lane.hs && (lp == CODE_STOP);
  assign c01_nx  = (c01 == CNT_MAX)  ? c01  : c01 + CNT_ONE;
  assign c00_nx  = (c00 == CNT_MAX)  ? c00  : c00 + CNT_ONE;
  assign plat_nx = (plat == CNT_MAX) ? plat : plat + CNT_ONE;
  assign short_plat = (plat < PLAT_T) || (c01 < TLPX_T) || (c00 < TLPX_T);

  always_comb begin
    nstate  = state;
    op      = OP_HOLD;
    do_ok   = 1'b0;
    do_flt  = 1'b0;
    clr_err = 1'b0;
    rcode   = FLT_NONE;
    rlen    = plat;
    case (state)
      ST_WAIT: begin
        if (is_stop) begin
          nstate  = ST_STOP;
          clr_err = 1'b1;
        end
      end
      ST_STOP: begin
        rlen = '0;
        if (lane.hs) begin
          do_flt = 1'b1; rcode = FLT_ABSENT; nstate = ST_WAIT;
        end else if (lp == CODE_LO1) begin
          nstate = ST_LO1; op = OP_NEW01;
        end else if (lp != CODE_STOP) begin
          do_flt = 1'b1; rcode = FLT_ORDER; nstate = ST_WAIT;
        end
      end
      ST_LO1: begin
        if (lane.hs) begin
          do_flt = 1'b1; rcode = FLT_ORDER; nstate = ST_WAIT;
        end else if (lp == CODE_LO1) begin
          op = OP_INC01;
        end else if (lp == CODE_LO0) begin
          nstate = ST_LO0; op = OP_NEW00;
        end else begin
          do_flt = 1'b1; rcode = FLT_ORDER; nstate = ST_WAIT;
        end
      end
      ST_LO0: begin
        if (lane.hs) begin
          if (short_plat) begin
            do_flt = 1'b1; rcode = FLT_TRUNC; nstate = ST_WAIT;
          end else begin
            do_ok = 1'b1; nstate = ST_BURST;
          end
        end else if (lp == CODE_LO0) begin
          op = OP_INC00;
        end else begin
          do_flt = 1'b1; rcode = FLT_ORDER; nstate = ST_WAIT;
        end
      end
      ST_BURST: begin
        if (is_stop) nstate = ST_STOP;
      end
      default: nstate = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_WAIT;
      c01    <= '0;
      c00    <= '0;
      plat   <= '0;
      ok_o   <= 1'b0;
      flt_o  <= 1'b0;
      code_o <= FLT_NONE;
      len_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      state  <= nstate;
      ok_o   <= do_ok;
      flt_o  <= do_flt;
      code_o <= rcode;
      len_o  <= (do_ok || do_flt) ? rlen : '0;
      if (do_flt)       err_o <= 1'b1;
      else if (clr_err) err_o <= 1'b0;
      case (op)
        OP_NEW01: begin c01 <= CNT_ONE; c00 <= '0; plat <= CNT_ONE; end
        OP_INC01: begin c01 <= c01_nx; plat <= plat_nx; end
        OP_NEW00: begin c00 <= CNT_ONE; plat <= plat_nx; end
        OP_INC00: begin c00 <= c00_nx; plat <= plat_nx; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/lp_entry_monitor.sv
module lp_entry_monitor
  import lpmon_pkg::*;
#(
  parameter int SAMPLE_PS = 2000,
  parameter int TLPX_PS   = 50000,
  parameter int PLAT_PS   = 50000,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_dp,
  input  logic             lp_dn,
  input  logic             hs_det,
  output logic             start_ok,
  output logic             start_fault,
  output logic [1:0]       fault_code,
  output logic [CNT_W-1:0] plat_len,
  output logic             err_flag
);
  localparam int TLPX_TICKS = (TLPX_PS + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam int PLAT_TICKS = (PLAT_PS + SAMPLE_PS - 1) / SAMPLE_PS;
  localparam logic [CNT_W-1:0] TLPX_T = CNT_W'(TLPX_TICKS);
  localparam logic [CNT_W-1:0] PLAT_T = CNT_W'(PLAT_TICKS);

  logic [LANE_W-1:0] raw_v, sync_v, filt_v;
  lane_t             lane;

  assign raw_v = {hs_det, lp_dp, lp_dn};

  lpmon_sync #(.W(LANE_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_v), .d_out(sync_v)
  );

  lpmon_deglitch #(.W(LANE_W)) u_filt (
    .clk(clk), .rst(rst), .d_in(sync_v), .d_out(filt_v)
  );

  assign lane = lane_t'(filt_v);

  lpmon_seq #(.CNT_W(CNT_W), .TLPX_T(TLPX_T), .PLAT_T(PLAT_T)) u_seq (
    .clk(clk), .rst(rst), .lane(lane),
    .ok_o(start_ok), .flt_o(start_fault), .code_o(fault_code),
    .len_o(plat_len), .err_o(err_flag)
  );
endmodule

// File: rtl/lp_entry_monitor_chk.sv
module lp_entry_monitor_chk #(
  parameter int               CNT_W  = 8,
  parameter logic [CNT_W-1:0] PLAT_T = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start_ok,
  input logic             start_fault,
  input logic [1:0]       fault_code,
  input logic [CNT_W-1:0] plat_len,
  input logic             err_flag
);
  p_single_verdict_r1: assert property (@(posedge clk) disable iff (rst)
    !(start_ok && start_fault));

  p_ok_clean_r1: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> (fault_code == 2'd0) && !err_flag);

  p_ok_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> !start_ok);

  p_ok_long_r2: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> (plat_len >= PLAT_T));

  p_absent_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (start_fault && fault_code == 2'd2) |-> (plat_len == '0));

  p_fault_coded_r5: assert property (@(posedge clk) disable iff (rst)
    start_fault |-> (fault_code != 2'd0));

  p_flag_with_fault_r6: assert property (@(posedge clk) disable iff (rst)
    start_fault |-> err_flag && !$past(err_flag));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> !err_flag && !start_ok && !start_fault);
endmodule

bind lp_entry_monitor lp_entry_monitor_chk #(.CNT_W(CNT_W), .PLAT_T(PLAT_T)) u_chk (
  .clk(clk), .rst(rst), .start_ok(start_ok), .start_fault(start_fault),
  .fault_code(fault_code), .plat_len(plat_len), .err_flag(err_flag)
);

// File: tb/lp_entry_monitor_tb.sv
`timescale 1ns/1ps
module lp_entry_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp_dp = 1'b1, lp_dn = 1'b1, hs_det = 1'b0;
  logic start_ok, start_fault, err_flag;
  logic [1:0] fault_code;
  logic [CNT_W-1:0] plat_len;

  int total = 0, bad = 0;
  int ok_seen = 0, flt_seen = 0;
  int cap_code = 0, cap_len = 0, cap_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // TLPX = 5 ticks, PLAT = 12 ticks
  lp_entry_monitor #(.SAMPLE_PS(10000), .TLPX_PS(50000), .PLAT_PS(120000), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .lp_dp(lp_dp), .lp_dn(lp_dn), .hs_det(hs_det),
    .start_ok(start_ok), .start_fault(start_fault), .fault_code(fault_code),
    .plat_len(plat_len), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (start_ok) ok_seen++;
    if (start_fault) flt_seen++;
    if (start_ok || start_fault) begin
      cap_code = fault_code;
      cap_len  = plat_len;
      cap_err  = err_flag;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lane(input logic h, input logic p, input logic n, input int cyc);
    hs_det = h; lp_dp = p; lp_dn = n;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic clear_caps();
    ok_seen = 0; flt_seen = 0; cap_code = -1; cap_len = -1; cap_err = -1;
  endtask

  task automatic entry(input int n01, input int n00, input int nhs);
    lane(0, 1, 1, 6);
    lane(0, 0, 1, n01);
    lane(0, 0, 0, n00);
    lane(1, 0, 0, nhs);
    lane(0, 1, 1, 8);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    lane(0, 1, 1, 4);
    chk(!start_ok && !start_fault && !err_flag, "R9 reset outputs", {start_ok, start_fault, err_flag}, 0);
    rst = 1'b0;
    lane(0, 1, 1, 6);
  endtask

  task automatic t_valid();
    clear_caps();
    entry(6, 6, 10);
    chk(ok_seen == 1 && flt_seen == 0, "R1 good start pulse", ok_seen, 1);
    chk(cap_code == 0, "R1 code", cap_code, 0);
    chk(cap_len == 12, "R1 plateau length", cap_len, 12);
  endtask

  task automatic t_short_total();
    clear_caps();
    entry(6, 5, 10);
    chk(flt_seen == 1 && ok_seen == 0, "R2 truncated fault", flt_seen, 1);
    chk(cap_code == 1, "R2 code", cap_code, 1);
    chk(cap_len == 11, "R2 length", cap_len, 11);
  endtask

  task automatic t_short_state();
    clear_caps();
    entry(10, 3, 10);
    chk(flt_seen == 1 && cap_code == 1, "R3 short LP-00", cap_code, 1);
    clear_caps();
    entry(3, 10, 10);
    chk(flt_seen == 1 && cap_code == 1, "R3 short LP-01", cap_code, 1);
  endtask

  task automatic t_absent();
    clear_caps();
    lane(0, 1, 1, 6);
    lane(1, 0, 0, 10);
    chk(flt_seen == 1 && cap_code == 2, "R4 absent code", cap_code, 2);
    chk(cap_len == 0, "R4 absent length", cap_len, 0);
    chk(cap_err == 1, "R6 flag in fault cycle", cap_err, 1);
    lane(0, 1, 1, 8);
  endtask

  task automatic t_order();
    clear_caps();
    lane(0, 1, 1, 6);
    lane(0, 0, 0, 8);
    chk(flt_seen == 1 && cap_code == 3, "R5 stop to 00", cap_code, 3);
    clear_caps();
    lane(0, 1, 1, 8);
    lane(0, 0, 1, 6);
    lane(0, 1, 0, 8);
    chk(flt_seen == 1 && cap_code == 3, "R5 01 to 10", cap_code, 3);
    chk(cap_len == 6, "R5 partial length", cap_len, 6);
    clear_caps();
    lane(0, 1, 1, 8);
    lane(0, 0, 1, 6);
    lane(1, 0, 1, 8);
    chk(flt_seen == 1 && cap_code == 3, "R5 01 to hs", cap_code, 3);
    lane(0, 1, 1, 8);
  endtask

  task automatic t_sticky();
    lane(0, 1, 1, 6);
    lane(1, 0, 0, 10);
    clear_caps();
    chk(err_flag == 1, "R6 flag held", err_flag, 1);
    lane(0, 0, 1, 6);
    lane(0, 0, 0, 6);
    lane(1, 0, 0, 10);
    chk(ok_seen == 0 && flt_seen == 0, "R6 silent while flagged", ok_seen + flt_seen, 0);
    chk(err_flag == 1, "R6 flag still held", err_flag, 1);
    lane(0, 1, 1, 8);
    chk(err_flag == 0, "R6 flag cleared by stop", err_flag, 0);
  endtask

  task automatic t_glitch();
    clear_caps();
    lane(0, 1, 1, 6);
    lane(0, 0, 1, 1);
    lane(0, 1, 1, 6);
    lane(1, 1, 1, 1);
    lane(0, 1, 1, 8);
    chk(ok_seen == 0 && flt_seen == 0 && err_flag == 0, "R7 glitch ignored", ok_seen + flt_seen, 0);
    entry(6, 6, 10);
    chk(ok_seen == 1 && cap_len == 12, "R7 normal after glitch", cap_len, 12);
  endtask

  task automatic t_saturate();
    clear_caps();
    entry(6, 300, 10);
    chk(ok_seen == 1 && cap_len == 255, "R8 saturated length", cap_len, 255);
  endtask

  task automatic t_mid_reset();
    clear_caps();
    lane(0, 1, 1, 6);
    lane(0, 0, 1, 4);
    rst = 1'b1;
    lane(0, 0, 1, 2);
    rst = 1'b0;
    lane(0, 0, 1, 4);
    lane(0, 0, 0, 6);
    lane(1, 0, 0, 10);
    chk(ok_seen == 0 && flt_seen == 0, "R9 ignores lane until stop", ok_seen + flt_seen, 0);
    lane(0, 1, 1, 6);
    entry(6, 6, 10);
    chk(ok_seen == 1 && flt_seen == 0, "R9 resumes after stop", ok_seen, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_valid();
    t_short_total();
    t_short_state();
    t_absent();
    t_order();
    t_sticky();
    t_glitch();
    t_saturate();
    t_mid_reset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule